// File: doc/BRIEF.md
# Audio Word FIFO Pair with Watermark Interrupts

This block sits between a software-facing register interface and a serial audio engine. It holds two independent first-in first-out queues of 32-bit audio words: a transmit queue that software fills and the serial engine drains, and a receive queue that the serial engine fills and software drains. Both queues share one clock and one synchronous active-low reset.

Each queue reports its fill level as a 6-bit count, with full and empty flags. Each can be emptied at once by a one-cycle flush pulse. Software picks a watermark threshold for each direction by writing a small code, and the block turns that code into a word count through a fixed, non-linear table. The two directions use different tables and compare in opposite senses. The receive watermark fires when enough data has arrived to be worth reading. The transmit watermark fires when the queue is running low and needs refilling.

Two event interrupts complete the set. One is a single-cycle pulse when the transmit queue drains to empty. The other is a single-cycle pulse when the serial engine delivers a word that the full receive queue cannot hold.

Top module: `audio_fifo_pair`

## Requirements
- R1: After reset both levels are 0, both empty flags are 1 and both full flags are 0. Words written with `txq_wr` leave on `txq_head` in the order written. Each accepted write or pop changes `txq_level` by one on the next clock edge. `txq_full` is 1 exactly at level 32 and `txq_empty` is 1 exactly at level 0.
- R2: Words pushed with `rxq_push` appear on `rxq_rd_data` in the order pushed. `rxq_level` counts them. A read strobe while the receive queue is empty leaves the level at 0, and `rxq_rd_data` reads 0 while the queue is empty.
- R3: A push while the receive queue holds 32 words, with no flush in that cycle, is dropped and the stored words are unchanged. `irq_rx_overflow` is 1 for exactly the one cycle after that push.
- R4: The receive threshold code (3 bits) maps 0→1, 1→4, 2→8, 3→16, 4→30 words, and 5, 6 and 7 also map to 30. `irq_rx_watermark` is 1 while `rxq_level` is greater than or equal to the threshold.
- R5: The transmit threshold code (2 bits) maps 0→2, 1→4, 2→8, 3→16 words. `irq_tx_watermark` is 1 while `txq_level` is strictly less than the threshold.
- R6: Both threshold codes reset to 2. A `cfg_we` pulse loads `cfg_rx_code` and `cfg_tx_code` together. The stored codes are visible on `rx_code_q` and `tx_code_q` from the next cycle.
- R7: A one-cycle `txq_flush` or `rxq_flush` pulse empties that queue on the next edge. A flush takes priority over a push or write in the same cycle. The flush inputs are pulses and are not stored, so no flush state can be read back.
- R8: `irq_tx_empty` is 1 for exactly one cycle: the first cycle in which `txq_empty` is 1 after having been 0. It stays 0 after reset.
- R9: A write while the transmit queue is full is dropped and the level stays 32. A pop while the transmit queue is empty is ignored and the level stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txq_wr | input | 1 | Software write strobe, transmit queue |
| txq_wr_data | input | 32 | Word to append to the transmit queue |
| txq_pop | input | 1 | Serial engine takes the head word |
| txq_head | output | 32 | Oldest transmit word, 0 when empty |
| rxq_push | input | 1 | Serial engine delivers a received word |
| rxq_push_data | input | 32 | Received word |
| rxq_rd | input | 1 | Software read strobe, receive queue |
| rxq_rd_data | output | 32 | Oldest receive word, 0 when empty |
| txq_flush | input | 1 | Empty the transmit queue |
| rxq_flush | input | 1 | Empty the receive queue |
| cfg_we | input | 1 | Load both threshold codes |
| cfg_rx_code | input | 3 | Receive threshold code |
| cfg_tx_code | input | 2 | Transmit threshold code |
| rx_code_q | output | 3 | Stored receive threshold code |
| tx_code_q | output | 2 | Stored transmit threshold code |
| txq_level | output | 6 | Transmit fill level |
| rxq_level | output | 6 | Receive fill level |
| txq_full | output | 1 | Transmit queue full |
| txq_empty | output | 1 | Transmit queue empty |
| rxq_full | output | 1 | Receive queue full |
| rxq_empty | output | 1 | Receive queue empty |
| irq_tx_watermark | output | 1 | Transmit level below threshold |
| irq_tx_empty | output | 1 | Pulse on transmit queue draining to empty |
| irq_rx_watermark | output | 1 | Receive level at or above threshold |
| irq_rx_overflow | output | 1 | Pulse after a push into a full receive queue |

## Verification
The hardest state to reach is the receive overflow. It needs all 32 entries occupied and then one more push. After that, the bench has to show that the extra word never entered storage, not only that the interrupt pulsed. The bench fills the queue with numbered words and pushes a distinct marker word. It then drains all 32 entries and compares each against its number, so the marker would appear if it had been stored. The top threshold of 30 and the three codes that alias to it are also only reachable with a nearly full queue, so each receive code is tested by filling exactly to one below and then exactly to the threshold.

// File: rtl/afp_pkg.sv
// Package: shared widths and threshold decode tables for the audio FIFO pair.
// Assumes level counts fit in LVL_W bits (queue depth of at most 63).
package afp_pkg;
    localparam int LVL_W = 6;

    // Receive threshold table; unused codes alias to the largest level.
    function automatic logic [LVL_W-1:0] rx_thr(input logic [2:0] code);
        logic [LVL_W-1:0] t;
        case (code)
            3'd0:    t = LVL_W'(1);
            3'd1:    t = LVL_W'(4);
            3'd2:    t = LVL_W'(8);
            3'd3:    t = LVL_W'(16);
            default: t = LVL_W'(30);
        endcase
        return t;
    endfunction

    // Transmit threshold table.
    function automatic logic [LVL_W-1:0] tx_thr(input logic [1:0] code);
        logic [LVL_W-1:0] t;
        case (code)
            2'd0:    t = LVL_W'(2);
            2'd1:    t = LVL_W'(4);
            2'd2:    t = LVL_W'(8);
            default: t = LVL_W'(16);
        endcase
        return t;
    endfunction
endpackage

// File: rtl/afp_fifo.sv
// Module: afp_fifo
// Synchronous show-ahead queue. A push while full and a pop while empty
// are ignored. A flush empties the queue and overrides push and pop.
// The head reads zero when empty.
// Assumes DEPTH is a power of two so the pointers wrap naturally.
module afp_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 32,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] head,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [LVL_W-1:0] cnt;
    logic             do_push;
    logic             do_pop;

    // Qualify requests against the present occupancy.
    always_comb begin
        full    = (cnt == LVL_W'(DEPTH));
        empty   = (cnt == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
    end

    // Pointer and occupancy update, flush first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + LVL_W'(do_push) - LVL_W'(do_pop);
        end
    end

    // Storage write; the array needs no reset.
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= push_data;
    end

    // Show-ahead head word, zero when nothing is stored.
    always_comb begin
        head  = empty ? '0 : mem[rd_ptr];
        level = cnt;
    end

    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LVL_W'(DEPTH));
    assert_pop_empty_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> (cnt == '0));
    assert_full_push_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (full && $stable(wr_ptr)));
    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/afp_watermark.sv
// Module: afp_watermark
// Turns a threshold code into a word count and compares it with a fill level.
// RX_SIDE=1: at or above the threshold. RX_SIDE=0: strictly below it.
// Assumes the code width matches the chosen table (3 receive, 2 transmit).
module afp_watermark #(
    parameter bit RX_SIDE = 1'b1,
    parameter int CODE_W  = 3,
    parameter int LVL_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic [LVL_W-1:0]  level,
    output logic              wm
);
    logic [LVL_W-1:0] thr;

    generate
        if (RX_SIDE) begin : g_rx
            // Receive table, compare at-or-above.
            always_comb begin
                thr = LVL_W'(afp_pkg::rx_thr(3'(code)));
                wm  = (level >= thr);
            end
            assert_rx_wm_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
                wm |-> (level != '0));
        end else begin : g_tx
            // Transmit table, compare strictly-below.
            always_comb begin
                thr = LVL_W'(afp_pkg::tx_thr(2'(code)));
                wm  = (level < thr);
            end
            assert_tx_wm_high_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (level >= LVL_W'(16)) |-> !wm);
        end
    endgenerate
endmodule

// File: rtl/audio_fifo_pair.sv
// Module: audio_fifo_pair (top)
// Transmit and receive audio word queues with threshold code registers,
// watermark levels, a transmit-drained pulse and a receive-overflow pulse.
// Assumes a single clock domain; bus decoding lives outside.
module audio_fifo_pair #(
    parameter int WORD_W    = 32,
    parameter int DEPTH     = 32,
    parameter int RX_CODE_W = 3,
    parameter int TX_CODE_W = 2,
    parameter int LVL_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 txq_wr,
    input  logic [WORD_W-1:0]    txq_wr_data,
    input  logic                 txq_pop,
    output logic [WORD_W-1:0]    txq_head,
    input  logic                 rxq_push,
    input  logic [WORD_W-1:0]    rxq_push_data,
    input  logic                 rxq_rd,
    output logic [WORD_W-1:0]    rxq_rd_data,
    input  logic                 txq_flush,
    input  logic                 rxq_flush,
    input  logic                 cfg_we,
    input  logic [RX_CODE_W-1:0] cfg_rx_code,
    input  logic [TX_CODE_W-1:0] cfg_tx_code,
    output logic [RX_CODE_W-1:0] rx_code_q,
    output logic [TX_CODE_W-1:0] tx_code_q,
    output logic [LVL_W-1:0]     txq_level,
    output logic [LVL_W-1:0]     rxq_level,
    output logic                 txq_full,
    output logic                 txq_empty,
    output logic                 rxq_full,
    output logic                 rxq_empty,
    output logic                 irq_tx_watermark,
    output logic                 irq_tx_empty,
    output logic                 irq_rx_watermark,
    output logic                 irq_rx_overflow
);
    localparam logic [RX_CODE_W-1:0] RX_CODE_RST = RX_CODE_W'(2);
    localparam logic [TX_CODE_W-1:0] TX_CODE_RST = TX_CODE_W'(2);

    logic prev_tx_empty;
    logic rx_ovf_q;

    // Threshold code registers, loaded together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_code_q <= RX_CODE_RST;
            tx_code_q <= TX_CODE_RST;
        end else if (cfg_we) begin
            rx_code_q <= cfg_rx_code;
            tx_code_q <= cfg_tx_code;
        end
    end

    afp_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(txq_wr), .push_data(txq_wr_data),
        .pop(txq_pop), .flush(txq_flush),
        .head(txq_head), .level(txq_level),
        .full(txq_full), .empty(txq_empty)
    );

    afp_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rxq_push), .push_data(rxq_push_data),
        .pop(rxq_rd), .flush(rxq_flush),
        .head(rxq_rd_data), .level(rxq_level),
        .full(rxq_full), .empty(rxq_empty)
    );

    afp_watermark #(.RX_SIDE(1'b1), .CODE_W(RX_CODE_W), .LVL_W(LVL_W)) u_rx_wm (
        .clk(clk), .rst_n(rst_n), .code(rx_code_q),
        .level(rxq_level), .wm(irq_rx_watermark)
    );

    afp_watermark #(.RX_SIDE(1'b0), .CODE_W(TX_CODE_W), .LVL_W(LVL_W)) u_tx_wm (
        .clk(clk), .rst_n(rst_n), .code(tx_code_q),
        .level(txq_level), .wm(irq_tx_watermark)
    );

    // Event history: previous transmit-empty flag and overflow capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_tx_empty <= 1'b1;
            rx_ovf_q      <= 1'b0;
        end else begin
            prev_tx_empty <= txq_empty;
            rx_ovf_q      <= rxq_push && rxq_full && !rxq_flush;
        end
    end

    // Event interrupt outputs.
    always_comb begin
        irq_tx_empty    = txq_empty && !prev_tx_empty;
        irq_rx_overflow = rx_ovf_q;
    end

    assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx_overflow |-> $past(rxq_push && rxq_full));
    assert_ovf_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx_overflow |-> (rxq_level != '0));
    assert_txe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_empty |=> !irq_tx_empty);
    assert_txe_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_empty |-> txq_empty);
    assert_code_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (rx_code_q == $past(cfg_rx_code) && tx_code_q == $past(cfg_tx_code)));
endmodule

// File: tb/test_audio_fifo_pair.sv
// Directed bench for audio_fifo_pair: one task per scenario.
module test_audio_fifo_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txq_wr = 0, txq_pop = 0, rxq_push = 0, rxq_rd = 0;
    logic [31:0] txq_wr_data = 0, rxq_push_data = 0;
    logic        txq_flush = 0, rxq_flush = 0, cfg_we = 0;
    logic [2:0]  cfg_rx_code = 0;
    logic [1:0]  cfg_tx_code = 0;
    logic [31:0] txq_head, rxq_rd_data;
    logic [2:0]  rx_code_q;
    logic [1:0]  tx_code_q;
    logic [5:0]  txq_level, rxq_level;
    logic        txq_full, txq_empty, rxq_full, rxq_empty;
    logic        irq_tx_watermark, irq_tx_empty, irq_rx_watermark, irq_rx_overflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    audio_fifo_pair i_audio_fifo_pair (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tx_write(input logic [31:0] d);
        @(negedge clk); txq_wr = 1; txq_wr_data = d;
        @(negedge clk); txq_wr = 0;
    endtask

    task automatic rx_push_word(input logic [31:0] d);
        @(negedge clk); rxq_push = 1; rxq_push_data = d;
        @(negedge clk); rxq_push = 0;
    endtask

    task automatic set_codes(input logic [2:0] rc, input logic [1:0] tc);
        @(negedge clk); cfg_we = 1; cfg_rx_code = rc; cfg_tx_code = tc;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic flush_both();
        @(negedge clk); txq_flush = 1; rxq_flush = 1;
        @(negedge clk); txq_flush = 0; rxq_flush = 0;
    endtask

    task automatic t_reset_state();
        check("R1 tx level", 32'(txq_level), 0);
        check("R1 rx level", 32'(rxq_level), 0);
        check("R1 empties", {txq_empty, rxq_empty}, 2'b11);
        check("R1 fulls", {txq_full, rxq_full}, 2'b00);
        check("R6 codes reset", {rx_code_q, tx_code_q}, {3'd2, 2'd2});
        check("R5 tx wm at reset", 32'(irq_tx_watermark), 1);
        check("R4 rx wm at reset", 32'(irq_rx_watermark), 0);
        check("R8 no tx empty irq after reset", 32'(irq_tx_empty), 0);
        check("R3 no ovf after reset", 32'(irq_rx_overflow), 0);
    endtask

    task automatic t_tx_order();
        for (int i = 0; i < 32; i++) tx_write(32'hA500_0000 + i);
        check("R1 tx full level", 32'(txq_level), 32);
        check("R1 tx full flag", 32'(txq_full), 1);
        tx_write(32'hDEAD_BEEF);
        check("R9 tx write when full dropped", 32'(txq_level), 32);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            check("R1 tx order", txq_head, 32'hA500_0000 + i);
            txq_pop = 1;
            @(negedge clk); txq_pop = 0;
            if (i == 31) begin
                check("R8 tx empty pulse", 32'(irq_tx_empty), 1);
                check("R1 tx empty flag", 32'(txq_empty), 1);
            end
        end
        @(negedge clk);
        check("R8 tx empty pulse ends", 32'(irq_tx_empty), 0);
        txq_pop = 1;
        @(negedge clk); txq_pop = 0;
        check("R9 tx pop when empty ignored", 32'(txq_level), 0);
    endtask

    task automatic t_rx_thresholds();
        logic [5:0] thr;
        for (int c = 0; c < 8; c++) begin
            case (c)
                0: thr = 1; 1: thr = 4; 2: thr = 8; 3: thr = 16;
                default: thr = 30;
            endcase
            flush_both();
            set_codes(3'(c), 2'd0);
            check("R6 rx code readback", 32'(rx_code_q), c);
            for (int k = 0; k < int'(thr) - 1; k++) rx_push_word(32'(k));
            check("R4 rx wm below thr", 32'(irq_rx_watermark), 0);
            rx_push_word(32'h55);
            check("R4 rx wm at thr", 32'(irq_rx_watermark), 1);
        end
    endtask

    task automatic t_tx_thresholds();
        logic [5:0] thr;
        for (int c = 0; c < 4; c++) begin
            case (c)
                0: thr = 2; 1: thr = 4; 2: thr = 8; default: thr = 16;
            endcase
            flush_both();
            set_codes(3'd0, 2'(c));
            check("R6 tx code readback", 32'(tx_code_q), c);
            for (int k = 0; k < int'(thr) - 1; k++) tx_write(32'(k));
            check("R5 tx wm below thr", 32'(irq_tx_watermark), 1);
            tx_write(32'h66);
            check("R5 tx wm at thr", 32'(irq_tx_watermark), 0);
        end
    endtask

    task automatic t_rx_overflow();
        flush_both();
        for (int i = 0; i < 32; i++) rx_push_word(32'hC000_0000 + i);
        check("R3 rx full", 32'(rxq_full), 1);
        check("R3 no ovf yet", 32'(irq_rx_overflow), 0);
        @(negedge clk); rxq_push = 1; rxq_push_data = 32'hBAD0_BAD0;
        @(negedge clk); rxq_push = 0;
        check("R3 ovf pulse", 32'(irq_rx_overflow), 1);
        check("R3 level held", 32'(rxq_level), 32);
        @(negedge clk);
        check("R3 ovf pulse one cycle", 32'(irq_rx_overflow), 0);
        for (int i = 0; i < 32; i++) begin
            check("R3 R2 rx contents and order", rxq_rd_data, 32'hC000_0000 + i);
            rxq_rd = 1;
            @(negedge clk); rxq_rd = 0;
        end
        check("R2 rx drained", 32'(rxq_level), 0);
        check("R2 empty read data zero", rxq_rd_data, 0);
        rxq_rd = 1;
        @(negedge clk); rxq_rd = 0;
        check("R2 read when empty no level change", 32'(rxq_level), 0);
    endtask

    task automatic t_flush_priority();
        tx_write(32'h1); rx_push_word(32'h2);
        @(negedge clk);
        txq_flush = 1; txq_wr = 1; txq_wr_data = 32'h7;
        rxq_flush = 1; rxq_push = 1; rxq_push_data = 32'h8;
        @(negedge clk);
        txq_flush = 0; txq_wr = 0; rxq_flush = 0; rxq_push = 0;
        check("R7 tx flush wins", 32'(txq_level), 0);
        check("R7 rx flush wins", 32'(rxq_level), 0);
        check("R7 rx data zero after flush", rxq_rd_data, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset_state();
        t_tx_order();
        t_rx_thresholds();
        t_tx_thresholds();
        t_rx_overflow();
        t_flush_priority();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule